// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Buffer

This block receives characters from an asynchronous serial line. An external oversampling tick drives it. A start bit is accepted only when it is confirmed at the centre of the bit. The block then collects 5 to 9 data bits, an optional parity bit and one stop bit. Each finished character is stored together with its own error flags.

Storage is a two-entry buffer plus a one-character hold slot. The hold slot represents the shift register that still contains a finished character. The host sees the oldest character on its read outputs and removes it with a one-cycle pop. An overrun is recorded when a new start bit is confirmed while the buffer and the hold slot are both occupied. In multiprocessor mode, frames whose address bit is 0 are thrown away.

Top module: `serial_rx_fifo`

## Requirements
- R1: `char_size_i` selects the number of data bits: 000=5, 001=6, 010=7, 011=8 and 111=9. The codes 100, 101 and 110 behave as 8. Data bits arrive LSB first. Unused upper bits of `rd_data_o` read 0. `rd_bit8_o` carries data bit 8 in 9-bit mode and is 0 in every other mode.
- R2: A falling line starts a start-bit check. If the majority of the three centre samples is high, the receiver returns to idle and stores nothing.
- R3: With `dbl_speed_i`=0 a bit lasts 16 ticks and is sampled by majority of ticks 7, 8 and 9. With `dbl_speed_i`=1 a bit lasts 8 ticks and ticks 3, 4 and 5 are used.
- R4: Characters leave the buffer oldest first. A pop while `rx_avail_o` is 0 has no effect.
- R5: `parity_mode_i` selects the parity: 00=off, 10=even, 11=odd, and 01 behaves as off. A received parity bit that does not match sets `parity_err_o` for that character.
- R6: `frame_err_o` is 1 when the first stop bit of the head character was sampled low. Only one stop bit is checked.
- R7: A new start bit confirmed while both buffer entries and the hold slot are full sets the overrun flag of the held character and discards the new frame. On the outputs, `overrun_o` can only rise after a pop.
- R8: The error flags and the 9th bit travel with their own character. The head outputs stay constant until a pop.
- R9: `rx_avail_o` is 1 exactly when unread characters are present. After reset it is 0 and all flags are 0.
- R10: `rx_en_i`=0 empties the buffer and the hold slot and returns the receiver to idle. All read outputs are 0 on the next cycle.
- R11: With `mpc_mode_i`=1, a frame is dropped when its address bit is 0. The address bit is data bit 8 in 9-bit mode and the first stop bit in the shorter modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Oversampling tick, one clock wide |
| rx_en_i | input | 1 | Receiver enable; low flushes the buffer |
| dbl_speed_i | input | 1 | 8 ticks per bit instead of 16 |
| char_size_i | input | 3 | Character length code |
| parity_mode_i | input | 2 | Parity mode code |
| mpc_mode_i | input | 1 | Drop frames whose address bit is 0 |
| rxd_i | input | 1 | Serial line, idle high |
| rd_pop_i | input | 1 | Remove the head character |
| rx_avail_o | output | 1 | Unread character present |
| rd_data_o | output | 8 | Head character, bits 7:0 |
| rd_bit8_o | output | 1 | Head character, bit 8 |
| frame_err_o | output | 1 | Head character had a low stop bit |
| parity_err_o | output | 1 | Head character had a parity mismatch |
| overrun_o | output | 1 | A frame following the head character was lost |

## Verification
A pop of the head and the move of the held character into the buffer happen in the same cycle. The held character must take the freed tail position, keep its own flags and leave the hold slot empty. The bench provokes this by letting three frames arrive unread, sometimes followed by a fourth that overruns. It then drains the buffer one pop at a time and compares the order, the data and the flags against its own queue model. The checker also requires the head outputs to stay put when there is no pop, and `overrun_o` to rise only after a pop.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned DATA_W = 9;

  typedef struct packed {
    logic              ovr;
    logic              pe;
    logic              fe;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame import srx_pkg::*; #(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       dbl_i,
  input  logic [2:0] size_i,
  input  logic [1:0] par_i,
  input  logic       mpc_i,
  input  logic       hold_full_i,
  output logic       start_ok_o,
  output logic       push_o,
  output rx_entry_t  entry_o
);
  localparam int unsigned CNT_W = $clog2(OSR + 1);
  localparam logic [CNT_W-1:0] TPB_N = CNT_W'(OSR);
  localparam logic [CNT_W-1:0] TPB_D = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] MID_N = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] MID_D = CNT_W'(OSR / 4);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, tpb, mid;
  logic              s0_q, s1_q, drop_q, par_acc_q, par_bit_q;
  logic [3:0]        bit_idx_q, last_idx;
  logic [DATA_W-1:0] shreg_q;
  logic              bit_v, decide, addr_bit;

  always_comb begin
    case (size_i)
      3'b000:  last_idx = 4'd4;
      3'b001:  last_idx = 4'd5;
      3'b010:  last_idx = 4'd6;
      3'b111:  last_idx = 4'd8;
      default: last_idx = 4'd7;
    endcase
  end

  assign tpb        = dbl_i ? TPB_D : TPB_N;
  assign mid        = dbl_i ? MID_D : MID_N;
  assign cnt_nx     = cnt_q + ONE;
  assign bit_v      = (s0_q & s1_q) | (s0_q & rx_i) | (s1_q & rx_i);
  assign decide     = en_i && tick_i && (state_q != ST_IDLE) && (cnt_nx == mid + ONE);
  assign start_ok_o = decide && (state_q == ST_START) && !bit_v;
  // address bit: data bit 8 in 9-bit mode, first stop bit otherwise
  assign addr_bit   = (last_idx == 4'd8) ? shreg_q[8] : bit_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      s0_q      <= 1'b1;
      s1_q      <= 1'b1;
      drop_q    <= 1'b0;
      par_acc_q <= 1'b0;
      par_bit_q <= 1'b0;
      bit_idx_q <= '0;
      shreg_q   <= '0;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        drop_q  <= 1'b0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= ONE;
          end
        end else begin
          cnt_q <= (cnt_nx == tpb) ? '0 : cnt_nx;
          if (cnt_nx == mid - ONE) s0_q <= rx_i;
          if (cnt_nx == mid)       s1_q <= rx_i;
        end
        if (decide) begin
          case (state_q)
            ST_START: begin
              if (bit_v) state_q <= ST_IDLE;
              else begin
                state_q   <= ST_DATA;
                drop_q    <= hold_full_i;
                bit_idx_q <= '0;
                par_acc_q <= 1'b0;
                shreg_q   <= '0;
              end
            end
            ST_DATA: begin
              shreg_q[bit_idx_q] <= bit_v;
              par_acc_q          <= par_acc_q ^ bit_v;
              bit_idx_q          <= bit_idx_q + 4'd1;
              if (bit_idx_q == last_idx) state_q <= par_i[1] ? ST_PAR : ST_STOP;
            end
            ST_PAR: begin
              par_bit_q <= bit_v;
              state_q   <= ST_STOP;
            end
            ST_STOP: begin
              state_q       <= ST_IDLE;
              push_o        <= !drop_q && !(mpc_i && !addr_bit);
              entry_o.data  <= shreg_q;
              entry_o.fe    <= !bit_v;
              entry_o.pe    <= par_i[1] & (par_bit_q ^ par_acc_q ^ par_i[0]);
              entry_o.ovr   <= 1'b0;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo import srx_pkg::*; #(
  parameter int unsigned DEPTH = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  input  logic      mark_i,
  output logic      hold_full_o,
  output rx_entry_t head_o,
  output logic      avail_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t       mem_q [DEPTH];
  rx_entry_t       hold_q, hold_m;
  logic            hold_v_q;
  logic [CW-1:0]   cnt_q, cnt_pop;
  logic            pop_ok, mark;

  assign pop_ok      = pop_i && (cnt_q != '0);
  assign cnt_pop     = cnt_q - CW'(pop_ok);
  assign hold_full_o = (cnt_q == FULL_CNT) && hold_v_q;
  assign mark        = mark_i && hold_full_o;
  assign head_o      = mem_q[0];
  assign avail_o     = cnt_q != '0;

  // overrun mark lands on the held entry, even while it moves
  always_comb begin
    hold_m     = hold_q;
    hold_m.ovr = hold_q.ovr | mark;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      cnt_q    <= '0;
      hold_v_q <= 1'b0;
    end else begin
      if (pop_ok)
        for (int i = 0; i < DEPTH - 1; i++) mem_q[i] <= mem_q[i+1];
      if (hold_v_q) begin
        if (pop_ok) begin
          mem_q[cnt_pop] <= hold_m;
          hold_v_q       <= 1'b0;
        end else begin
          hold_q <= hold_m;
        end
      end else if (push_i) begin
        if (cnt_pop < FULL_CNT) begin
          mem_q[cnt_pop] <= entry_i;
          cnt_q          <= cnt_pop + CW'(1);
        end else begin
          hold_q   <= entry_i;
          hold_v_q <= 1'b1;
          cnt_q    <= cnt_pop;
        end
      end else begin
        cnt_q <= cnt_pop;
      end
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo import srx_pkg::*; #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FIFO_DEPTH  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       rx_en_i,
  input  logic       dbl_speed_i,
  input  logic [2:0] char_size_i,
  input  logic [1:0] parity_mode_i,
  input  logic       mpc_mode_i,
  input  logic       rxd_i,
  input  logic       rd_pop_i,
  output logic       rx_avail_o,
  output logic [7:0] rd_data_o,
  output logic       rd_bit8_o,
  output logic       frame_err_o,
  output logic       parity_err_o,
  output logic       overrun_o
);
  logic      rx_s, start_ok, frm_push, hold_full, avail;
  rx_entry_t frm_entry, head;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  srx_frame #(.OSR(OSR)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en_i),
    .tick_i     (baud_tick_i),
    .rx_i       (rx_s),
    .dbl_i      (dbl_speed_i),
    .size_i     (char_size_i),
    .par_i      (parity_mode_i),
    .mpc_i      (mpc_mode_i),
    .hold_full_i(hold_full),
    .start_ok_o (start_ok),
    .push_o     (frm_push),
    .entry_o    (frm_entry)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (!rx_en_i),
    .push_i     (frm_push),
    .entry_i    (frm_entry),
    .pop_i      (rd_pop_i),
    .mark_i     (start_ok),
    .hold_full_o(hold_full),
    .head_o     (head),
    .avail_o    (avail)
  );

  assign rx_avail_o   = avail;
  assign rd_data_o    = avail ? head.data[7:0] : '0;
  assign rd_bit8_o    = avail & head.data[8];
  assign frame_err_o  = avail & head.fe;
  assign parity_err_o = avail & head.pe;
  assign overrun_o    = avail & head.ovr;
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       rd_pop_i,
  input logic       frm_push,
  input logic       rx_avail_o,
  input logic [7:0] rd_data_o,
  input logic       rd_bit8_o,
  input logic       frame_err_o,
  input logic       parity_err_o,
  input logic       overrun_o
);
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_avail_o); // R10

  AST_POP_EMPTY_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_avail_o && rd_pop_i && !frm_push) |=> !rx_avail_o); // R4

  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rx_avail_o && !rd_pop_i) |=>
      (rx_avail_o && $stable({rd_bit8_o, rd_data_o, frame_err_o, parity_err_o, overrun_o}))); // R8

  AST_AVAIL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_avail_o) |-> ($past(rd_pop_i) || !$past(rx_en_i))); // R9

  AST_OVR_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rd_pop_i)); // R7
endmodule

bind serial_rx_fifo serial_rx_fifo_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .rd_pop_i    (rd_pop_i),
  .frm_push    (frm_push),
  .rx_avail_o  (rx_avail_o),
  .rd_data_o   (rd_data_o),
  .rd_bit8_o   (rd_bit8_o),
  .frame_err_o (frame_err_o),
  .parity_err_o(parity_err_o),
  .overrun_o   (overrun_o)
);

// File: tb/serial_rx_fifo_tb.sv
`timescale 1ns/1ps
module serial_rx_fifo_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0, baud_tick_i = 1'b0;
  logic       rx_en_i = 1'b0, dbl_speed_i = 1'b0, mpc_mode_i = 1'b0;
  logic       rxd_i = 1'b1, rd_pop_i = 1'b0;
  logic [2:0] char_size_i = 3'b011;
  logic [1:0] parity_mode_i = 2'b00;
  logic       rx_avail_o, rd_bit8_o, frame_err_o, parity_err_o, overrun_o;
  logic [7:0] rd_data_o;

  int n_chk = 0, n_bad = 0;
  logic [11:0] mq[$]; // {ovr, pe, fe, data[8:0]}

  serial_rx_fifo u_dut (
    .clk_i, .rst_ni, .baud_tick_i, .rx_en_i, .dbl_speed_i, .char_size_i,
    .parity_mode_i, .mpc_mode_i, .rxd_i, .rd_pop_i, .rx_avail_o, .rd_data_o,
    .rd_bit8_o, .frame_err_o, .parity_err_o, .overrun_o
  );

  always #4 clk_i = ~clk_i;

  initial forever begin
    @(negedge clk_i);
    baud_tick_i = ~baud_tick_i;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [2:0] c);
    case (c)
      3'b000:  return 5;
      3'b001:  return 6;
      3'b010:  return 7;
      3'b111:  return 9;
      default: return 8;
    endcase
  endfunction

  task automatic drive(input logic v, input int n);
    rxd_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send(input logic [8:0] d, input bit flip_par, input bit bad_stop);
    int n, bc, lo;
    logic [8:0] dm;
    logic pbit, addr;
    logic [11:0] tmp;
    bit par_on;
    n      = nbits(char_size_i);
    bc     = dbl_speed_i ? 16 : 32;
    lo     = dbl_speed_i ? 15 : 22;
    dm     = d & ((9'h1 << n) - 9'h1);
    par_on = parity_mode_i[1];
    pbit   = ^dm ^ parity_mode_i[0] ^ flip_par;
    addr   = (n == 9) ? dm[8] : !bad_stop;
    if (mq.size() == 3) begin
      tmp = mq[2]; tmp[11] = 1'b1; mq[2] = tmp;
    end else if (!(mpc_mode_i && !addr)) begin
      mq.push_back({1'b0, par_on & flip_par, bad_stop, dm});
    end
    drive(1'b0, bc);
    for (int i = 0; i < n; i++) drive(dm[i], bc);
    if (par_on) drive(pbit, bc);
    if (bad_stop) begin
      drive(1'b0, lo);
      drive(1'b1, bc - lo);
    end else begin
      drive(1'b1, bc);
    end
    drive(1'b1, bc);
  endtask

  task automatic check_empty(input string req);
    chk(!rx_avail_o, req, rx_avail_o, 0);
    chk({overrun_o, parity_err_o, frame_err_o, rd_bit8_o, rd_data_o} == 12'h0, req,
        {overrun_o, parity_err_o, frame_err_o, rd_bit8_o, rd_data_o}, 0);
  endtask

  task automatic read_one(input string req);
    logic [11:0] act, exp;
    act = {overrun_o, parity_err_o, frame_err_o, rd_bit8_o, rd_data_o};
    if (mq.size() == 0) begin
      check_empty("R9");
      return;
    end
    exp = mq.pop_front();
    chk(rx_avail_o, "R9", rx_avail_o, 1);
    chk(act == exp, req, act, exp);
    rd_pop_i = 1'b1;
    @(negedge clk_i);
    rd_pop_i = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] sz, input logic [1:0] pm, input logic dbl, input logic mpc);
    char_size_i = sz; parity_mode_i = pm; dbl_speed_i = dbl; mpc_mode_i = mpc;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk_i);
    check_empty("R9 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    rx_en_i = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 lengths and masking
    cfg(3'b011, 2'b00, 1'b0, 1'b0); send(9'h0A5, 0, 0); read_one("R1 8b");
    cfg(3'b000, 2'b00, 1'b0, 1'b0); send(9'h1FF, 0, 0); read_one("R1 5b");
    cfg(3'b001, 2'b00, 1'b0, 1'b0); send(9'h1EA, 0, 0); read_one("R1 6b");
    cfg(3'b010, 2'b00, 1'b0, 1'b0); send(9'h1D5, 0, 0); read_one("R1 7b");
    cfg(3'b111, 2'b00, 1'b0, 1'b0); send(9'h1C3, 0, 0); read_one("R1 9b");
    cfg(3'b101, 2'b00, 1'b0, 1'b0); send(9'h13C, 0, 0); read_one("R1 reserved");

    // R5 parity
    cfg(3'b011, 2'b10, 1'b0, 1'b0); send(9'h033, 1, 0); read_one("R5 even bad");
    send(9'h071, 0, 0); read_one("R5 even ok");
    cfg(3'b011, 2'b11, 1'b0, 1'b0); send(9'h071, 0, 0); read_one("R5 odd ok");
    send(9'h0F0, 1, 0); read_one("R5 odd bad");
    cfg(3'b011, 2'b01, 1'b0, 1'b0); send(9'h066, 0, 0); read_one("R5 reserved");

    // R6 framing
    cfg(3'b011, 2'b00, 1'b0, 1'b0); send(9'h081, 0, 1); read_one("R6 fe");
    cfg(3'b111, 2'b10, 1'b0, 1'b0); send(9'h1A5, 1, 1); read_one("R6 fe+pe");

    // R3 double speed
    cfg(3'b011, 2'b11, 1'b1, 1'b0); send(9'h05A, 0, 0); read_one("R3 dbl");
    cfg(3'b111, 2'b00, 1'b1, 1'b0); send(9'h155, 0, 0); read_one("R3 dbl 9b");

    // R2 false start
    cfg(3'b011, 2'b00, 1'b0, 1'b0);
    drive(1'b0, 4); drive(1'b1, 64);
    check_empty("R2 glitch");
    send(9'h0C7, 0, 0); read_one("R2 after glitch");

    // R4 order and pop on empty
    send(9'h011, 0, 0); send(9'h022, 0, 1); send(9'h033, 0, 0);
    read_one("R4 first"); read_one("R4 second"); read_one("R4 third");
    check_empty("R4 drained");
    rd_pop_i = 1'b1; @(negedge clk_i); rd_pop_i = 1'b0; @(negedge clk_i);
    check_empty("R4 pop empty");

    // R7 overrun
    send(9'h041, 0, 0); send(9'h042, 0, 0); send(9'h043, 0, 0); send(9'h044, 0, 0);
    read_one("R7 first"); read_one("R7 second"); read_one("R7 held");
    check_empty("R7 lost frame");
    send(9'h045, 0, 0); read_one("R7 recovered");

    // R11 multiprocessor
    cfg(3'b111, 2'b00, 1'b0, 1'b1);
    send(9'h055, 0, 0); check_empty("R11 data frame dropped");
    send(9'h155, 0, 0); read_one("R11 address frame");
    cfg(3'b011, 2'b00, 1'b0, 1'b1);
    send(9'h0AA, 0, 1); check_empty("R11 short dropped");
    send(9'h0AB, 0, 0); read_one("R11 short kept");

    // R10 flush
    cfg(3'b011, 2'b10, 1'b0, 1'b0);
    send(9'h0E1, 1, 0); send(9'h0E2, 0, 1);
    rx_en_i = 1'b0; @(negedge clk_i); @(negedge clk_i);
    check_empty("R10 flush");
    mq.delete();
    rx_en_i = 1'b1; @(negedge clk_i);
    send(9'h0E3, 0, 0); read_one("R10 after flush");

    // random traffic
    for (int f = 0; f < 60; f++) begin
      logic [2:0] sz;
      logic [1:0] pm;
      int k;
      case ($urandom_range(0, 4))
        0: sz = 3'b000; 1: sz = 3'b001; 2: sz = 3'b010; 3: sz = 3'b011; default: sz = 3'b111;
      endcase
      case ($urandom_range(0, 2))
        0: pm = 2'b00; 1: pm = 2'b10; default: pm = 2'b11;
      endcase
      cfg(sz, pm, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      send(9'($urandom), ($urandom_range(0, 6) == 0), ($urandom_range(0, 9) == 0));
      k = $urandom_range(0, 2);
      for (int r = 0; r < k; r++) read_one("R8 random");
    end
    while (mq.size() != 0) read_one("R8 drain");
    check_empty("R9 end");
    finish_run();
  end
endmodule